// File: doc/BRIEF.md
# Condition-Register Field Mask Logic Unit

This block owns a 32-bit condition register split into eight 4-bit fields. Within a field the bits stand for less-than, greater-than, equal and overflow, from the most significant bit down. On a strobe it runs one of three operations, and each one weighs several field bits together. Every bit is gated by its own mask bit and compared against its own mode bit. The operations are: spreading one integer bit into a whole field, folding a field into a single CR bit, and folding a field into a 0/1 integer result that can optionally be summarised into field 0.

Field `f` occupies CR bits `31-4f` down to `28-4f`, so field 0 is the top nibble. Within a field, intermediate bit `n_i` (i = 0..3) uses `mask_i[i]` and `mode_i[i]`. Bit `n0` sits at the field's most significant position. The control is a two-state machine. `ST_IDLE` moves to `ST_RESP` when `valid_i` is high. `ST_RESP` stays in `ST_RESP` while `valid_i` remains high and returns to `ST_IDLE` otherwise. `done_o` is high exactly in `ST_RESP`.

Top module: `crml_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `cr_o`, `int_o` and `done_o` become zero.
- R2: Opcode 0 (insert) computes `n_i = mask_i[i] & (mode_i[i] == int_i[0])` and writes `{n0,n1,n2,n3}` into field `fld_i`, with `n0` at the field's most significant bit.
- R3: An insert leaves every field other than `fld_i` unchanged.
- R4: Opcode 1 (fold) computes `n_i = mask_i[i] & (mode_i[i] == s_i)`, where `s_i` is bit i of field `fld_i` counted from its most significant bit. It ORs the four `n_i` when `red_sel_i[0]` is 1 and ANDs them when it is 0.
- R5: A fold writes its result to CR bit `31 - bit_i`, so `bit_i` 0 is the most significant CR bit. All other CR bits are unchanged.
- R6: Opcode 2 (extract) forms the same `n_i` as a fold and reduces them by `red_sel_i`: 0 gives AND, 1 gives OR, and 2 or 3 give XOR. `int_o` becomes the 0/1 result zero-extended to 64 bits.
- R7: An extract with `rec_i` set writes field 0 as {less-than = result negative, greater-than = result positive, equal = result zero, overflow = 0}. With `rec_i` clear, an extract leaves the CR unchanged.
- R8: An operation strobed at one edge has its CR and `int_o` effects visible after that edge, and `done_o` is high for the following cycle. Strobes on consecutive cycles each complete and keep `done_o` high.
- R9: Opcode 3 is reserved. It changes neither the CR nor `int_o`, but `done_o` still pulses.
- R10: With `valid_i` low, the CR and `int_o` hold and `done_o` is low on the next cycle.
- R11: Only an extract changes `int_o`. Inserts and folds leave it at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 0 insert, 1 fold, 2 extract, 3 reserved |
| mask_i | input | 4 | Per-bit gate; bit i gates n_i |
| mode_i | input | 4 | Per-bit compare value; bit i serves n_i |
| red_sel_i | input | 2 | Reduction select (fold uses bit 0 only) |
| rec_i | input | 1 | Record flag for extract |
| fld_i | input | 3 | Target field (insert) or source field (fold, extract) |
| bit_i | input | 5 | Destination CR bit for fold, 0 = MSB |
| int_i | input | 64 | Integer operand; bit 0 used by insert |
| cr_o | output | 32 | Condition register |
| int_o | output | 64 | Integer result of the last extract |
| done_o | output | 1 | High for the cycle after each strobe |

## Verification
Every result is due one edge after the strobe. The CR write, the `int_o` update and the rise of `done_o` all come from the same edge, through a single register stage. The bench drives inputs on the falling edge and then samples all three outputs on the next falling edge, half a cycle after the edge that registered them. Back-to-back strobes are checked in the same way, one falling edge apart. An idle cycle is sampled one falling edge after `valid_i` drops, to confirm that `done_o` is low and that the state has held.

// File: rtl/crml_pkg.sv
package crml_pkg;

    typedef enum logic [1:0] {
        OP_INS  = 2'd0,
        OP_FOLD = 2'd1,
        OP_EXT  = 2'd2,
        OP_RSV  = 2'd3
    } crml_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } crml_state_e;

    typedef enum logic [1:0] {
        RED_AND  = 2'd0,
        RED_OR   = 2'd1,
        RED_XOR  = 2'd2,
        RED_XORB = 2'd3
    } crml_red_e;

endpackage

// File: rtl/crml_lane.sv
module crml_lane #(
    parameter int FBITS = 4
) (
    input  logic [FBITS-1:0] fld_vec,
    input  logic [FBITS-1:0] mask,
    input  logic [FBITS-1:0] mode,
    input  logic             use_ref,
    input  logic             ref_bit,
    output logic [FBITS-1:0] n
);
    // n[i] is n_i; source bit i of the field is counted from its MSB
    for (genvar i = 0; i < FBITS; i++) begin : g_bit
        logic src;
        always_comb begin
            src  = use_ref ? ref_bit : fld_vec[FBITS-1-i];
            n[i] = mask[i] & (mode[i] == src);
        end
    end
endmodule

// File: rtl/crml_reduce.sv
module crml_reduce #(
    parameter int FBITS = 4
) (
    input  logic [FBITS-1:0] n,
    input  logic [1:0]       sel,
    output logic             y
);
    import crml_pkg::*;
    always_comb begin
        unique case (crml_red_e'(sel))
            RED_AND:  y = &n;
            RED_OR:   y = |n;
            RED_XOR,
            RED_XORB: y = ^n;
            default:  y = 1'b0;
        endcase
    end
endmodule

// File: rtl/crml_writer.sv
module crml_writer #(
    parameter int FIELDS = 8,
    parameter int FBITS  = 4,
    parameter int XLEN   = 64,
    localparam int CRW   = FIELDS * FBITS,
    localparam int FSELW = $clog2(FIELDS),
    localparam int BSELW = $clog2(CRW)
) (
    input  logic [CRW-1:0]   cr_q,
    input  logic [1:0]       op,
    input  logic [FSELW-1:0] fld,
    input  logic [BSELW-1:0] bsel,
    input  logic [FBITS-1:0] n,
    input  logic             fold_bit,
    input  logic [XLEN-1:0]  ext_res,
    input  logic             rec,
    output logic [CRW-1:0]   cr_d
);
    import crml_pkg::*;

    logic [FBITS-1:0] ins_val;
    logic [FBITS-1:0] rec_val;

    // field layout: n0 at the field MSB
    for (genvar i = 0; i < FBITS; i++) begin : g_rev
        assign ins_val[FBITS-1-i] = n[i];
    end

    always_comb begin
        rec_val          = '0;
        rec_val[FBITS-1] = ext_res[XLEN-1];
        rec_val[FBITS-2] = !ext_res[XLEN-1] && (ext_res != '0);
        rec_val[FBITS-3] = (ext_res == '0);
    end

    for (genvar f = 0; f < FIELDS; f++) begin : g_fld
        localparam int LO = CRW - FBITS * (f + 1);
        for (genvar b = 0; b < FBITS; b++) begin : g_b
            localparam int POS = LO + b;
            always_comb begin
                cr_d[POS] = cr_q[POS];
                unique case (crml_op_e'(op))
                    OP_INS: begin
                        if (fld == FSELW'(f)) cr_d[POS] = ins_val[b];
                    end
                    OP_FOLD: begin
                        if (bsel == BSELW'(CRW - 1 - POS)) cr_d[POS] = fold_bit;
                    end
                    OP_EXT: begin
                        if (rec && f == 0) cr_d[POS] = rec_val[b];
                    end
                    OP_RSV: cr_d[POS] = cr_q[POS];
                    default: cr_d[POS] = cr_q[POS];
                endcase
            end
        end
    end
endmodule

// File: rtl/crml_unit.sv
module crml_unit #(
    parameter int FIELDS = 8,
    parameter int FBITS  = 4,
    parameter int XLEN   = 64,
    localparam int CRW   = FIELDS * FBITS,
    localparam int FSELW = $clog2(FIELDS),
    localparam int BSELW = $clog2(CRW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [1:0]       op_i,
    input  logic [FBITS-1:0] mask_i,
    input  logic [FBITS-1:0] mode_i,
    input  logic [1:0]       red_sel_i,
    input  logic             rec_i,
    input  logic [FSELW-1:0] fld_i,
    input  logic [BSELW-1:0] bit_i,
    input  logic [XLEN-1:0]  int_i,
    output logic [CRW-1:0]   cr_o,
    output logic [XLEN-1:0]  int_o,
    output logic             done_o
);
    import crml_pkg::*;

    crml_state_e state_q, state_d;
    logic [CRW-1:0]   cr_q, cr_d;
    logic [XLEN-1:0]  int_q;
    logic [FBITS-1:0] src_vec, n;
    logic             use_ref, fold_bit, ext_bit;
    logic [XLEN-1:0]  ext_res;

    assign src_vec = cr_q[(FIELDS - 1 - int'(fld_i)) * FBITS +: FBITS];
    assign use_ref = (crml_op_e'(op_i) == OP_INS);
    assign ext_res = {{(XLEN-1){1'b0}}, ext_bit};

    crml_lane #(.FBITS(FBITS)) lane_i (
        .fld_vec(src_vec), .mask(mask_i), .mode(mode_i),
        .use_ref(use_ref), .ref_bit(int_i[0]), .n(n)
    );

    crml_reduce #(.FBITS(FBITS)) fold_red_i (
        .n(n), .sel({1'b0, red_sel_i[0]}), .y(fold_bit)
    );

    crml_reduce #(.FBITS(FBITS)) ext_red_i (
        .n(n), .sel(red_sel_i), .y(ext_bit)
    );

    crml_writer #(.FIELDS(FIELDS), .FBITS(FBITS), .XLEN(XLEN)) wr_i (
        .cr_q(cr_q), .op(op_i), .fld(fld_i), .bsel(bit_i), .n(n),
        .fold_bit(fold_bit), .ext_res(ext_res), .rec(rec_i), .cr_d(cr_d)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = valid_i ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = valid_i ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q  <= '0;
            int_q <= '0;
        end else if (valid_i) begin
            cr_q <= cr_d;
            if (crml_op_e'(op_i) == OP_EXT) int_q <= ext_res;
        end
    end

    // outputs
    always_comb begin
        cr_o   = cr_q;
        int_o  = int_q;
        done_o = (state_q == ST_RESP);
    end
endmodule

// File: rtl/crml_chk.sv
module crml_chk #(
    parameter int CRW  = 32,
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            valid_i,
    input logic [1:0]      op_i,
    input logic            rec_i,
    input logic [CRW-1:0]  cr_o,
    input logic [XLEN-1:0] int_o,
    input logic            done_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (cr_o == '0 && int_o == '0 && !done_o));
    // R8
    done_follow_chk: assert property (@(posedge clk) disable iff (rst) valid_i |=> done_o);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!done_o && $stable(cr_o) && $stable(int_o)));
    // R5
    fold_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 2'd1) |=> $countones(cr_o ^ $past(cr_o)) <= 1);
    // R7
    ext_norec_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 2'd2 && !rec_i) |=> $stable(cr_o));
    // R7
    ext_rec_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 2'd2 && rec_i) |=>
            (!cr_o[CRW-1] && !cr_o[CRW-4] && $onehot(cr_o[CRW-2 -: 2])));
    // R6
    int_binary_chk: assert property (@(posedge clk) disable iff (rst) int_o[XLEN-1:1] == '0);
    // R9
    rsv_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 2'd3) |=> ($stable(cr_o) && $stable(int_o)));
endmodule

bind crml_unit crml_chk #(.CRW(CRW), .XLEN(XLEN)) chk_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .rec_i(rec_i),
    .cr_o(cr_o), .int_o(int_o), .done_o(done_o)
);

// File: tb/crml_unit_tb_top.sv
`timescale 1ns/1ps
module crml_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [1:0]  op_i = '0;
    logic [3:0]  mask_i = '0, mode_i = '0;
    logic [1:0]  red_sel_i = '0;
    logic        rec_i = 1'b0;
    logic [2:0]  fld_i = '0;
    logic [4:0]  bit_i = '0;
    logic [63:0] int_i = '0;
    logic [31:0] cr_o;
    logic [63:0] int_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_cr = '0;
    logic [63:0] m_int = '0;

    always #5 clk = ~clk;

    crml_unit dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .mask_i(mask_i),
        .mode_i(mode_i), .red_sel_i(red_sel_i), .rec_i(rec_i), .fld_i(fld_i),
        .bit_i(bit_i), .int_i(int_i), .cr_o(cr_o), .int_o(int_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] gate(input logic [3:0] f, input logic [3:0] mk,
                                        input logic [3:0] md, input bit use_ref, input bit r);
        logic [3:0] n;
        for (int i = 0; i < 4; i++)
            n[i] = mk[i] & (md[i] == (use_ref ? r : f[3-i]));
        return n;
    endfunction

    function automatic logic [3:0] field_of(input logic [31:0] c, input int f);
        return c[31-4*f -: 4];
    endfunction

    // model update per requirements R2..R9, R11
    task automatic model(input logic [1:0] op, input logic [3:0] mk, input logic [3:0] md,
                         input logic [1:0] rs, input bit rc, input logic [2:0] fl,
                         input logic [4:0] bt, input logic [63:0] iv);
        logic [3:0] n, v;
        logic r;
        n = gate(field_of(m_cr, fl), mk, md, op == 2'd0, iv[0]);
        case (op)
            2'd0: begin
                for (int i = 0; i < 4; i++) v[3-i] = n[i];
                m_cr[31-4*fl -: 4] = v;
            end
            2'd1: m_cr[31-bt] = rs[0] ? |n : &n;
            2'd2: begin
                r = (rs == 2'd0) ? &n : (rs == 2'd1) ? |n : ^n;
                m_int = {63'd0, r};
                if (rc) m_cr[31:28] = {1'b0, r, !r, 1'b0};
            end
            default: ;
        endcase
    endtask

    task automatic do_op(input logic [1:0] op, input logic [3:0] mk, input logic [3:0] md,
                         input logic [1:0] rs, input bit rc, input logic [2:0] fl,
                         input logic [4:0] bt, input logic [63:0] iv, input bit hold,
                         input string tag);
        valid_i = 1'b1; op_i = op; mask_i = mk; mode_i = md; red_sel_i = rs;
        rec_i = rc; fld_i = fl; bit_i = bt; int_i = iv;
        model(op, mk, md, rs, rc, fl, bt, iv);
        @(negedge clk);
        check(cr_o == m_cr, tag, {32'd0, cr_o}, {32'd0, m_cr});
        check(int_o == m_int, tag, int_o, m_int);
        check(done_o == 1'b1, {tag, " R8 done"}, {63'd0, done_o}, 64'd1);
        if (!hold) valid_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        int unsigned seed;
        seed = $urandom(32'd1357);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cr_o == 32'd0 && int_o == 64'd0 && done_o == 1'b0, "R1 reset",
              {31'd0, done_o, cr_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        // R2 insert into field 0 and field 7 with odd/even operands
        do_op(2'd0, 4'b1111, 4'b1010, 2'd0, 1'b0, 3'd0, 5'd0, 64'h3, 1'b0, "R2 ins f0");
        do_op(2'd0, 4'b0111, 4'b0101, 2'd0, 1'b0, 3'd7, 5'd0, 64'h2, 1'b0, "R2 ins f7");
        // R3 other fields untouched
        do_op(2'd0, 4'b1111, 4'b1111, 2'd0, 1'b0, 3'd3, 5'd0, 64'h1, 1'b0, "R3 ins f3");
        // R4 fold AND / OR, R5 bit 0 and bit 31
        do_op(2'd1, 4'b1111, 4'b1111, 2'd0, 1'b0, 3'd3, 5'd0, 64'h0, 1'b0, "R4 fold and");
        do_op(2'd1, 4'b0001, 4'b0000, 2'd1, 1'b0, 3'd0, 5'd31, 64'h0, 1'b0, "R5 fold bit31");
        // R6 extract AND / OR / XOR, R7 with and without record
        do_op(2'd2, 4'b1111, 4'b1010, 2'd0, 1'b1, 3'd0, 5'd0, 64'h0, 1'b0, "R6 ext and rec");
        do_op(2'd2, 4'b1000, 4'b0000, 2'd1, 1'b1, 3'd5, 5'd0, 64'h0, 1'b0, "R7 ext or rec");
        do_op(2'd2, 4'b1011, 4'b0110, 2'd2, 1'b0, 3'd7, 5'd0, 64'h0, 1'b0, "R7 ext xor norec");
        // R9 reserved opcode, R11 insert leaves int_o
        do_op(2'd3, 4'b1111, 4'b0000, 2'd3, 1'b1, 3'd0, 5'd3, 64'h1, 1'b0, "R9 rsv");
        do_op(2'd0, 4'b1111, 4'b0000, 2'd0, 1'b0, 3'd1, 5'd0, 64'h0, 1'b0, "R11 ins keeps int");
        // R10 idle cycle
        @(negedge clk);
        check(done_o == 1'b0 && cr_o == m_cr && int_o == m_int, "R10 idle",
              {31'd0, done_o, cr_o}, {32'd0, m_cr});
        // R8 back-to-back strobes
        do_op(2'd0, 4'b1111, 4'b1100, 2'd0, 1'b0, 3'd2, 5'd0, 64'h1, 1'b1, "R8 b2b a");
        do_op(2'd1, 4'b1111, 4'b1100, 2'd1, 1'b0, 3'd2, 5'd9, 64'h0, 1'b1, "R8 b2b b");
        do_op(2'd2, 4'b1111, 4'b1100, 2'd2, 1'b1, 3'd2, 5'd0, 64'h0, 1'b0, "R8 b2b c");
        // constrained random mix
        for (int k = 0; k < 400; k++) begin
            logic [1:0] op;
            op = 2'($urandom_range(0, 3));
            do_op(op, 4'($urandom), 4'($urandom), 2'($urandom), 1'($urandom),
                  3'($urandom), 5'($urandom), {$urandom, $urandom}, 1'($urandom),
                  op == 2'd0 ? "R2 rand" : op == 2'd1 ? "R4 rand" :
                  op == 2'd2 ? "R6 rand" : "R9 rand");
        end
        valid_i = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0, "R10 end idle", {63'd0, done_o}, 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule